// File: doc/BRIEF.md
# Lock Elision Nesting and Commit Controller

This controller keeps track of speculative regions in which lock operations are elided. It takes one event per cycle on a single event channel. An event is either an acquire or a release, and it carries a lock address, a lock value and an instruction pointer.

The controller holds the following state:
- a nesting depth that cannot exceed a configurable limit,
- an active flag,
- the restart pointer, taken from the outermost acquire,
- a small buffer of address/value pairs, one pair for each elided lock.

When the outermost release closes a region, the controller asks an external agent to commit the transaction and then waits for a pass or fail answer. Any failed rule starts an abort. The abort returns all state to idle, hands the saved restart pointer to the pipeline, and tells the pipeline to ignore elision hints when it executes that instruction again. Register checkpointing, write tracking and re-execution are handled outside this block.

Top module: `elide_ctrl`

## Requirements
- R1: After reset, nest_count is 0 and active, abort, commit_req and ignore_hints are all 0, while ev_ready is 1.
- R2: An accepted acquire (ev_kind = 0) raises nest_count by one on the next cycle if nest_count is below MAX_NEST. If nest_count already equals MAX_NEST, the acquire aborts instead.
- R3: An acquire that raises nest_count from 0 to 1 sets active and saves ev_ip as restart_ip. An acquire at a deeper level leaves restart_ip unchanged.
- R4: An acquire that does not abort stores its address and value in the free buffer entry with the lowest index. If no entry is free, the acquire still nests, and no entry is taken.
- R5: An accepted release (ev_kind = 1) with nest_count above 0 lowers nest_count by one. If its address equals that of an allocated entry (the lowest matching index is used), the entry is freed when the release value equals the stored value. If the values differ, the release aborts.
- R6: When a release brings nest_count to 0 and no entry remains allocated, commit_req is 1 from the next cycle. If any entry remains allocated, the release aborts.
- R7: While a commit is outstanding, commit_done with commit_ok = 1 clears active and commit_req on the next cycle. commit_done with commit_ok = 0 aborts. commit_done is ignored when no commit is outstanding.
- R8: A release accepted while nest_count is 0 changes no state.
- R9: An abort produces abort = 1 for exactly the one cycle after the triggering edge. The abort clears nest_count, active, commit_req and every buffer entry. restart_ip keeps the saved pointer.
- R10: ignore_hints goes to 1 together with abort. It stays at 1 until the next accepted event, which clears it unless that event aborts again.
- R11: ev_ready is 0 while commit_req is 1. An event presented during that time is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present |
| ev_kind | input | 1 | 0 = acquire, 1 = release |
| ev_addr | input | ADDR_W | Lock address |
| ev_value | input | DATA_W | Lock value |
| ev_ip | input | IP_W | Instruction pointer of the event |
| ev_ready | output | 1 | Event accepted when high |
| commit_req | output | 1 | Commit requested, held until answered |
| commit_done | input | 1 | Commit answer valid |
| commit_ok | input | 1 | Commit succeeded |
| abort | output | 1 | One-cycle abort pulse |
| restart_ip | output | IP_W | Saved restart pointer |
| ignore_hints | output | 1 | Re-execute without elision hints |
| active | output | 1 | Elided region in progress |
| nest_count | output | $clog2(MAX_NEST+1) | Current nesting depth |

## Verification
Two functions can act on a single release in the same cycle: freeing the matched buffer entry and checking whether the nesting has reached zero. If the entry was the last one allocated, the zero check must see the buffer as already empty and raise a commit request, not an abort. The bench provokes this with directed nests whose final release frees the last entry. It also provokes it in a random stream that draws addresses from a pool of four, so matches are frequent. A per-cycle reference model decides the expected result, and each cycle the bench checks that commit_req rises and abort stays low when the final release frees the last entry.

// File: rtl/elide_pkg.sv
package elide_pkg;
    typedef enum logic {
        EV_ACQ = 1'b0,
        EV_REL = 1'b1
    } ev_kind_e;
endpackage

// File: rtl/elide_pick.sv
module elide_pick #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/elide_buf.sv
module elide_buf #(
    parameter int ENTRIES = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_en,
    input  logic [IW-1:0]              alloc_idx,
    input  logic [ADDR_W-1:0]          alloc_addr,
    input  logic [DATA_W-1:0]          alloc_data,
    input  logic                       free_en,
    input  logic [IW-1:0]              free_idx,
    input  logic                       clear_all,
    output logic [ENTRIES-1:0]         vld,
    output logic [ENTRIES*ADDR_W-1:0]  addr_flat,
    output logic [ENTRIES*DATA_W-1:0]  data_flat
);
    logic [ENTRIES-1:0]        vld_d, vld_q;
    logic [ENTRIES*ADDR_W-1:0] addr_d, addr_q;
    logic [ENTRIES*DATA_W-1:0] data_d, data_q;

    always_comb begin
        vld_d  = vld_q;
        addr_d = addr_q;
        data_d = data_q;
        if (clear_all) begin
            vld_d = '0;
        end else begin
            if (free_en) begin
                vld_d[free_idx] = 1'b0;
            end
            if (alloc_en) begin
                vld_d[alloc_idx] = 1'b1;
                addr_d[alloc_idx*ADDR_W +: ADDR_W] = alloc_addr;
                data_d[alloc_idx*DATA_W +: DATA_W] = alloc_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            vld_q  <= vld_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign vld       = vld_q;
    assign addr_flat = addr_q;
    assign data_flat = data_q;
endmodule

// File: rtl/elide_ctrl.sv
module elide_ctrl
    import elide_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int IP_W      = 32,
    parameter int MAX_NEST  = 4,
    parameter int ENTRIES   = 2,
    localparam int CNT_W    = $clog2(MAX_NEST + 1),
    localparam int IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_value,
    input  logic [IP_W-1:0]   ev_ip,
    output logic              ev_ready,
    output logic              commit_req,
    input  logic              commit_done,
    input  logic              commit_ok,
    output logic              abort,
    output logic [IP_W-1:0]   restart_ip,
    output logic              ignore_hints,
    output logic              active,
    output logic [CNT_W-1:0]  nest_count
);
    typedef struct packed {
        logic [CNT_W-1:0] nest;
        logic             active;
        logic [IP_W-1:0]  rip;
        logic             pend;
        logic             abort;
        logic             ign;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ENTRIES-1:0]        buf_vld;
    logic [ENTRIES*ADDR_W-1:0] buf_addr;
    logic [ENTRIES*DATA_W-1:0] buf_data;
    logic [ENTRIES-1:0]        hit_vec;
    logic                      free_found, hit_found;
    logic [IW-1:0]             free_idx, hit_idx;
    logic                      alloc_en, rel_en, clear_all;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_hit
            assign hit_vec[g] = buf_vld[g] && (buf_addr[g*ADDR_W +: ADDR_W] == ev_addr);
        end
    endgenerate

    elide_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (
        .req   (~buf_vld),
        .found (free_found),
        .idx   (free_idx)
    );

    elide_pick #(.N(ENTRIES), .IW(IW)) u_hit_pick (
        .req   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    always_comb begin
        logic                accept;
        logic                abort_now;
        logic [ENTRIES-1:0]  remain;
        ctl_d      = ctl_q;
        ctl_d.abort = 1'b0;
        alloc_en   = 1'b0;
        rel_en     = 1'b0;
        clear_all  = 1'b0;
        abort_now  = 1'b0;
        remain     = buf_vld;
        accept     = ev_valid && !ctl_q.pend;

        if (accept && ev_kind_e'(ev_kind) == EV_ACQ) begin
            if (ctl_q.nest == CNT_W'(MAX_NEST)) begin
                abort_now = 1'b1;
            end else begin
                ctl_d.nest = ctl_q.nest + 1'b1;
                if (ctl_q.nest == '0) begin
                    ctl_d.active = 1'b1;
                    ctl_d.rip    = ev_ip;
                end
                alloc_en = free_found;
            end
        end

        if (accept && ev_kind_e'(ev_kind) == EV_REL && ctl_q.nest != '0) begin
            ctl_d.nest = ctl_q.nest - 1'b1;
            if (hit_found) begin
                if (buf_data[hit_idx*DATA_W +: DATA_W] == ev_value) begin
                    rel_en          = 1'b1;
                    remain[hit_idx] = 1'b0;
                end else begin
                    abort_now = 1'b1;
                end
            end
            if (!abort_now && ctl_q.nest == CNT_W'(1)) begin
                if (remain == '0) begin
                    ctl_d.pend = 1'b1;
                end else begin
                    abort_now = 1'b1;
                end
            end
        end

        if (ctl_q.pend && commit_done) begin
            if (commit_ok) begin
                ctl_d.active = 1'b0;
                ctl_d.pend   = 1'b0;
            end else begin
                abort_now = 1'b1;
            end
        end

        if (accept) begin
            ctl_d.ign = 1'b0;
        end

        if (abort_now) begin
            ctl_d.nest   = '0;
            ctl_d.active = 1'b0;
            ctl_d.pend   = 1'b0;
            ctl_d.abort  = 1'b1;
            ctl_d.ign    = 1'b1;
            clear_all    = 1'b1;
            alloc_en     = 1'b0;
            rel_en       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    elide_buf #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_idx  (free_idx),
        .alloc_addr (ev_addr),
        .alloc_data (ev_value),
        .free_en    (rel_en),
        .free_idx   (hit_idx),
        .clear_all  (clear_all),
        .vld        (buf_vld),
        .addr_flat  (buf_addr),
        .data_flat  (buf_data)
    );

    assign ev_ready     = !ctl_q.pend;
    assign commit_req   = ctl_q.pend;
    assign abort        = ctl_q.abort;
    assign restart_ip   = ctl_q.rip;
    assign ignore_hints = ctl_q.ign;
    assign active       = ctl_q.active;
    assign nest_count   = ctl_q.nest;
endmodule

// File: rtl/elide_chk.sv
module elide_chk #(
    parameter int MAX_NEST = 4,
    parameter int CNT_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_kind,
    input logic             ev_ready,
    input logic             commit_req,
    input logic             abort,
    input logic             ignore_hints,
    input logic             active,
    input logic [CNT_W-1:0] nest_count
);
    // R9
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (nest_count == '0 && !active && !commit_req));

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> !ev_ready);

    // R2
    nest_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_count <= CNT_W'(MAX_NEST));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_kind && nest_count == '0)
        |=> (nest_count == '0 && !commit_req && !abort));

    // R6
    commit_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_req) |-> (nest_count == '0 && active));

    // R10
    ignore_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ignore_hints);

    // R3
    idle_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> nest_count == '0);
endmodule

bind elide_ctrl elide_chk #(.MAX_NEST(MAX_NEST), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_ready     (ev_ready),
    .commit_req   (commit_req),
    .abort        (abort),
    .ignore_hints (ignore_hints),
    .active       (active),
    .nest_count   (nest_count)
);

// File: tb/sim_elide_ctrl.sv
`timescale 1ns/1ps
module sim_elide_ctrl;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int IPW = 32;
    localparam int MAXN = 4;
    localparam int ENT = 2;
    localparam int CW  = $clog2(MAXN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0, ev_kind = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [DW-1:0] ev_value = '0;
    logic [IPW-1:0] ev_ip = '0;
    logic commit_done = 1'b0, commit_ok = 1'b0;
    logic ev_ready, commit_req, abort, ignore_hints, active;
    logic [IPW-1:0] restart_ip;
    logic [CW-1:0] nest_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int unsigned m_cnt;
    bit m_act, m_pend, m_ab, m_ign;
    logic [IPW-1:0] m_rip;
    bit m_bv [ENT];
    logic [AW-1:0] m_ba [ENT];
    logic [DW-1:0] m_bd [ENT];

    always #2.5 clk = ~clk;

    elide_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IP_W(IPW), .MAX_NEST(MAXN), .ENTRIES(ENT)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_value(ev_value), .ev_ip(ev_ip), .ev_ready(ev_ready),
        .commit_req(commit_req), .commit_done(commit_done), .commit_ok(commit_ok),
        .abort(abort), .restart_ip(restart_ip), .ignore_hints(ignore_hints),
        .active(active), .nest_count(nest_count)
    );

    task automatic chk(string req, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic bit any_entry();
        bit r = 0;
        for (int i = 0; i < ENT; i++) r |= m_bv[i];
        return r;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_act = 0; m_pend = 0; m_ab = 0; m_ign = 0; m_rip = '0;
        for (int i = 0; i < ENT; i++) m_bv[i] = 0;
    endtask

    task automatic model_step(bit v, bit k, logic [AW-1:0] a, logic [DW-1:0] d,
                              logic [IPW-1:0] ip, bit cd, bit ok);
        bit acc = v && !m_pend;
        bit pend_old = m_pend;
        bit ab = 0;
        if (acc && !k) begin
            if (m_cnt == MAXN) ab = 1;
            else begin
                if (m_cnt == 0) begin m_act = 1; m_rip = ip; end
                m_cnt++;
                for (int i = 0; i < ENT; i++)
                    if (!m_bv[i]) begin m_bv[i] = 1; m_ba[i] = a; m_bd[i] = d; break; end
            end
        end
        if (acc && k && m_cnt != 0) begin
            m_cnt--;
            for (int i = 0; i < ENT; i++)
                if (m_bv[i] && m_ba[i] == a) begin
                    if (m_bd[i] == d) m_bv[i] = 0; else ab = 1;
                    break;
                end
            if (!ab && m_cnt == 0) begin
                if (any_entry()) ab = 1; else m_pend = 1;
            end
        end
        if (pend_old && cd) begin
            if (ok) begin m_act = 0; m_pend = 0; end else ab = 1;
        end
        if (acc) m_ign = 0;
        if (ab) begin
            m_cnt = 0; m_act = 0; m_pend = 0; m_ign = 1;
            for (int i = 0; i < ENT; i++) m_bv[i] = 0;
        end
        m_ab = ab;
    endtask

    task automatic compare_all();
        chk("R2", "nest_count", nest_count, m_cnt);
        chk("R3", "active", active, m_act);
        chk("R3", "restart_ip", restart_ip, m_rip);
        chk("R9", "abort", abort, m_ab);
        chk("R6", "commit_req", commit_req, m_pend);
        chk("R10", "ignore_hints", ignore_hints, m_ign);
        chk("R11", "ev_ready", ev_ready, !m_pend);
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(bit v, bit k, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [IPW-1:0] ip, bit cd, bit ok);
        ev_valid = v; ev_kind = k; ev_addr = a; ev_value = d; ev_ip = ip;
        commit_done = cd; commit_ok = ok;
        @(posedge clk);
        model_step(v, k, a, d, ip, cd, ok);
        @(negedge clk);
        ev_valid = 0; commit_done = 0;
        compare_all();
    endtask

    task automatic acq(logic [AW-1:0] a, logic [DW-1:0] d, logic [IPW-1:0] ip);
        step(1, 0, a, d, ip, 0, 0);
    endtask
    task automatic rel(logic [AW-1:0] a, logic [DW-1:0] d);
        step(1, 1, a, d, 32'h0, 0, 0);
    endtask
    task automatic idle(bit cd, bit ok);
        step(0, 0, 0, 0, 0, cd, ok);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "nest_count", nest_count, 0);
        chk("R1", "active", active, 0);
        chk("R1", "abort", abort, 0);
        chk("R1", "commit_req", commit_req, 0);
        chk("R1", "ignore_hints", ignore_hints, 0);
        chk("R1", "ev_ready", ev_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: buffer full, third lock unbuffered; R6: last release frees last entry -> commit
        acq(32'hA0, 32'h1, 32'h100);
        acq(32'hB0, 32'h2, 32'h200);
        chk("R3", "restart_ip kept at outer level", restart_ip, 32'h100);
        acq(32'hC0, 32'h3, 32'h300);
        chk("R4", "nest with no free entry", nest_count, 3);
        rel(32'hC0, 32'h3);
        chk("R4", "unbuffered release no abort", abort, 0);
        rel(32'hB0, 32'h2);
        rel(32'hA0, 32'h1);
        chk("R6", "commit_req after freeing last entry", commit_req, 1);
        chk("R6", "no abort when last entry freed", abort, 0);
        // R11 event ignored while commit pending
        acq(32'hD0, 32'h4, 32'h400);
        chk("R11", "acquire held off", nest_count, 0);
        // R7 commit passes
        idle(1, 1);
        chk("R7", "active cleared by commit", active, 0);
        chk("R7", "commit_req dropped", commit_req, 0);
        // R7 stray answer ignored
        idle(1, 0);
        chk("R7", "stray commit answer ignored", abort, 0);
        // R8 release at zero
        rel(32'hA0, 32'h1);
        chk("R8", "release at zero count", nest_count, 0);
        chk("R8", "release at zero no commit", commit_req, 0);

        // R5 value mismatch aborts
        acq(32'hA0, 32'h5, 32'h500);
        acq(32'hB0, 32'h6, 32'h600);
        rel(32'hB0, 32'h7);
        chk("R5", "mismatched value aborts", abort, 1);
        chk("R9", "restart_ip held on abort", restart_ip, 32'h500);
        chk("R10", "ignore_hints raised", ignore_hints, 1);
        idle(0, 0);
        chk("R9", "abort lasts one cycle", abort, 0);
        chk("R10", "ignore_hints holds until event", ignore_hints, 1);

        // R6 entry left at zero aborts
        acq(32'hA0, 32'h1, 32'h700);
        chk("R10", "ignore_hints cleared by event", ignore_hints, 0);
        rel(32'hE0, 32'h1);
        chk("R6", "remaining entry aborts", abort, 1);

        // R2 nest limit
        for (int i = 0; i < MAXN; i++) acq(32'h10 + i, 32'h0, 32'h800 + i);
        chk("R2", "nest at limit", nest_count, MAXN);
        acq(32'hF0, 32'h0, 32'h900);
        chk("R2", "acquire at limit aborts", abort, 1);
        chk("R9", "count cleared by abort", nest_count, 0);

        // R7 commit failure
        acq(32'hA0, 32'h1, 32'hA00);
        rel(32'hA0, 32'h1);
        idle(0, 0);
        chk("R7", "commit still pending", commit_req, 1);
        idle(1, 0);
        chk("R7", "failed commit aborts", abort, 1);

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            bit v, k, cd, ok;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            v  = ($urandom(seed) % 4) != 0;
            seed = seed + 1;
            k  = $urandom() % 2;
            a  = 32'h40 + ($urandom() % 4) * 4;
            d  = (($urandom() % 8) == 0) ? 32'h2 : 32'h1;
            cd = m_pend ? (($urandom() % 2) == 1) : (($urandom() % 8) == 0);
            ok = ($urandom() % 4) != 0;
            step(v, k, a, d, 32'h1000 + n, cd, ok);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule